// File: doc/BRIEF.md
# Interrupt Aggregator with Doorbell Sources

This block gathers a bank of interrupt sources into one level request for a parent interrupt controller. The low-numbered sources are wired inputs that are sensed as active-high levels. All other sources have no wire. A message writer sets one of them by writing that source's number as data to a single doorbell address. Both kinds of source share one set of pending (cause) bits and one set of disable (mask) bits. These bits are packed into 32-bit words that software reaches over a simple register bus.

Software unmasks the sources it services and waits for the aggregate request. It then reads the cause words to find the pending sources and retires each one by writing a one to its cause bit. During bring-up it writes all ones to every cause and mask word. This leaves nothing pending and every source disabled.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1 (all mask words read 0xFFFFFFFF), and `irq_out` is 0.
- R2: Source n lives in word n/32 at bit n%32. Cause word k is at address 0x00+4k and mask word k is at address 0x20+4k, so source 21 is bit 21 at 0x00 and source 63 is bit 31 at 0x04.
- R3: A write to a cause word clears each bit whose written data bit is 1. A written 0 leaves that bit unchanged.
- R4: A write to a mask word replaces the whole word, and a read returns the stored value. A mask bit of 1 disables its source and a mask bit of 0 enables it.
- R5: A write to address 0x30 whose data equals a source number from 21 to 63 sets that source's cause bit.
- R6: A doorbell write whose data is below 21 or above 63 changes no cause bit.
- R7: A wired source (0 to 20) sets its cause bit on every cycle its input is high. The bit stays set after the input falls, until a one is written to it.
- R8: If a clearing write hits a wired source whose input is high in the same cycle, the set wins and the bit stays 1.
- R9: `irq_out` is 1 exactly when some cause bit is 1 while its mask bit is 0.
- R10: Writing 0xFFFFFFFF to both cause words and both mask words leaves no cause pending and every source masked.
- R11: Read data appears on `reg_rdata` in the cycle after the `reg_rd` strobe. Unmapped addresses and the doorbell address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wired_irq | input | 21 | Level-high wired sources 0 to 20 |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data, or source number for the doorbell |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Aggregate level request to the parent |

## Verification
The bench drives three kinds of pattern.

- **Doorbell writes** cover the range edges 21 and 63 and the values 20, 64 and 0xFFFFFFFF. These separate a correct range decode from an off-by-one or a wrap of the source number.
- **Wired pulses** are checked in two forms. A single-cycle pulse must stay latched after the input falls. A held level is cleared in the same cycle it is sensed, and the bit must survive, which separates set priority from clear priority.
- **Mask patterns** cover a fully masked bank with causes pending and a single enabled source. These show that the request follows the masked AND of cause and mask and not either bank alone.

A behavioural model compares the request line and every read on each clock.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

   localparam int IDX_W = 4;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_DOOR  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e             sel;
      logic [IDX_W-1:0]     idx;
   } reg_hit_t;

endpackage

// File: rtl/irq_aggr_decode.sv
module irq_aggr_decode
   import irq_aggr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_REG    = 2,
   parameter int CAUSE_BASE = 'h00,
   parameter int MASK_BASE  = 'h20,
   parameter int DOOR_ADDR  = 'h30
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);

   always_comb begin
      hit.sel = SEL_NONE;
      hit.idx = '0;
      for (int r = 0; r < NUM_REG; r++) begin
         if (addr == ADDR_W'(CAUSE_BASE + 4 * r)) begin
            hit.sel = SEL_CAUSE;
            hit.idx = IDX_W'(r);
         end
         if (addr == ADDR_W'(MASK_BASE + 4 * r)) begin
            hit.sel = SEL_MASK;
            hit.idx = IDX_W'(r);
         end
      end
      if (addr == ADDR_W'(DOOR_ADDR)) begin
         hit.sel = SEL_DOOR;
         hit.idx = '0;
      end
   end

endmodule

// File: rtl/irq_aggr_doorbell.sv
module irq_aggr_doorbell #(
   parameter int NUM_SRC   = 64,
   parameter int WIRED_NUM = 21,
   parameter int DATA_W    = 32
) (
   input  logic              fire,
   input  logic [DATA_W-1:0] num,
   output logic [NUM_SRC-1:0] set_vec
);

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n < WIRED_NUM) begin : g_wired
         assign set_vec[n] = 1'b0;
      end else begin : g_msg
         assign set_vec[n] = fire && (num == DATA_W'(n));
      end
   end

endmodule

// File: rtl/irq_aggr_cause.sv
module irq_aggr_cause
   import irq_aggr_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int WIRED_NUM = 21,
   parameter int WORD_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIRED_NUM-1:0] wired_in,
   input  logic [NUM_SRC-1:0]   msg_set,
   input  logic                 clr_en,
   input  logic [IDX_W-1:0]     clr_idx,
   input  logic [WORD_W-1:0]    clr_bits,
   output logic [NUM_SRC-1:0]   cause_q
);

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
      localparam int WORD = n / WORD_W;
      localparam int POS  = n % WORD_W;
      logic set_now;
      logic clr_now;

      assign clr_now = clr_en && (clr_idx == IDX_W'(WORD)) && clr_bits[POS];

      if (n < WIRED_NUM) begin : g_level
         assign set_now = wired_in[n] | msg_set[n];
      end else begin : g_edge
         assign set_now = msg_set[n];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cause_q[n] <= 1'b0;
         else        cause_q[n] <= set_now | (cause_q[n] & ~clr_now);
      end
   end

endmodule

// File: rtl/irq_aggr_mask.sv
module irq_aggr_mask
   import irq_aggr_pkg::*;
#(
   parameter int NUM_REG = 2,
   parameter int WORD_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [WORD_W-1:0]         wr_data,
   output logic [NUM_REG*WORD_W-1:0] mask_q
);

   for (genvar r = 0; r < NUM_REG; r++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[r*WORD_W +: WORD_W] <= '1;
         else if (wr_en && wr_idx == IDX_W'(r))
            mask_q[r*WORD_W +: WORD_W] <= wr_data;
      end
   end

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
   import irq_aggr_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int WORD_W     = 32,
   parameter int WIRED_NUM  = 21,
   parameter int ADDR_W     = 8,
   parameter int CAUSE_BASE = 'h00,
   parameter int MASK_BASE  = 'h20,
   parameter int DOOR_ADDR  = 'h30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIRED_NUM-1:0] wired_irq,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 irq_out
);

   localparam int NUM_REG = NUM_SRC / WORD_W;

   if (NUM_REG * WORD_W != NUM_SRC) begin : g_bad_split
      $error("NUM_SRC must be a whole number of words");
   end
   if (WIRED_NUM < 1 || WIRED_NUM >= NUM_SRC) begin : g_bad_wired
      $error("WIRED_NUM must leave at least one doorbell source");
   end
   if (NUM_REG > (1 << IDX_W)) begin : g_bad_idx
      $error("too many words for the index field");
   end
   if (MASK_BASE < CAUSE_BASE + 4 * NUM_REG) begin : g_bad_map
      $error("mask words overlap cause words");
   end

   reg_hit_t                  hit;
   logic [NUM_SRC-1:0]        door_set;
   logic [NUM_SRC-1:0]        cause_q;
   logic [NUM_SRC-1:0]        mask_q;
   logic [WORD_W-1:0]         rd_word;

   irq_aggr_decode #(
      .ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .CAUSE_BASE(CAUSE_BASE),
      .MASK_BASE(MASK_BASE), .DOOR_ADDR(DOOR_ADDR)
   ) u_decode (
      .addr(reg_addr),
      .hit (hit)
   );

   irq_aggr_doorbell #(
      .NUM_SRC(NUM_SRC), .WIRED_NUM(WIRED_NUM), .DATA_W(WORD_W)
   ) u_door (
      .fire   (reg_wr && hit.sel == SEL_DOOR),
      .num    (reg_wdata),
      .set_vec(door_set)
   );

   irq_aggr_cause #(
      .NUM_SRC(NUM_SRC), .WIRED_NUM(WIRED_NUM), .WORD_W(WORD_W)
   ) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .wired_in(wired_irq),
      .msg_set (door_set),
      .clr_en  (reg_wr && hit.sel == SEL_CAUSE),
      .clr_idx (hit.idx),
      .clr_bits(reg_wdata),
      .cause_q (cause_q)
   );

   irq_aggr_mask #(
      .NUM_REG(NUM_REG), .WORD_W(WORD_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr && hit.sel == SEL_MASK),
      .wr_idx (hit.idx),
      .wr_data(reg_wdata),
      .mask_q (mask_q)
   );

   always_comb begin
      rd_word = '0;
      for (int r = 0; r < NUM_REG; r++) begin
         if (hit.idx == IDX_W'(r)) begin
            if (hit.sel == SEL_CAUSE) rd_word = cause_q[r*WORD_W +: WORD_W];
            if (hit.sel == SEL_MASK)  rd_word = mask_q[r*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_word;
   end

   assign irq_out = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
   parameter int NUM_SRC    = 64,
   parameter int WORD_W     = 32,
   parameter int WIRED_NUM  = 21,
   parameter int ADDR_W     = 8,
   parameter int MASK_BASE  = 'h20,
   parameter int DOOR_ADDR  = 'h30
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [WIRED_NUM-1:0] wired_irq,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [WORD_W-1:0]    reg_wdata,
   input logic [NUM_SRC-1:0]   cause_q,
   input logic [NUM_SRC-1:0]   mask_q,
   input logic                 irq_out
);

   localparam int NUM_REG = NUM_SRC / WORD_W;
   localparam int SRC_W   = $clog2(NUM_SRC);

   // R5: an in-range doorbell sets the addressed cause bit
   a_r5_door_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(DOOR_ADDR) &&
       reg_wdata >= WORD_W'(WIRED_NUM) && reg_wdata < WORD_W'(NUM_SRC))
      |=> cause_q[$past(reg_wdata[SRC_W-1:0])]);

   // R6: an out-of-range doorbell leaves the message causes unchanged
   a_r6_door_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(DOOR_ADDR) &&
       (reg_wdata < WORD_W'(WIRED_NUM) || reg_wdata >= WORD_W'(NUM_SRC)))
      |=> cause_q[NUM_SRC-1:WIRED_NUM] == $past(cause_q[NUM_SRC-1:WIRED_NUM]));

   // R7 and R8: a high wired input is pending next cycle, clear or not
   a_r7_wired_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|wired_irq)
      |=> (cause_q[WIRED_NUM-1:0] & $past(wired_irq)) == $past(wired_irq));

   // R3: a write of all zeros never clears a pending cause
   a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata == '0)
      |=> (cause_q & $past(cause_q)) == $past(cause_q));

   // R4: a mask word takes the written value
   for (genvar r = 0; r < NUM_REG; r++) begin : g_mask_chk
      a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == ADDR_W'(MASK_BASE + 4 * r))
         |=> mask_q[r*WORD_W +: WORD_W] == $past(reg_wdata));
   end

   // R9: nothing is requested while every source is masked or nothing pends
   a_r9_quiet_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq_out);
   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q == '0) |-> !irq_out);

endmodule

bind irq_aggr_top irq_aggr_chk #(
   .NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .WIRED_NUM(WIRED_NUM),
   .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE), .DOOR_ADDR(DOOR_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wired_irq(wired_irq),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .cause_q  (cause_q),
   .mask_q   (mask_q),
   .irq_out  (irq_out)
);

// File: tb/tb_irq_aggr_top.sv
module tb_irq_aggr_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] wired = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          mc [64];
   bit          mm [64];
   logic [31:0] m_rdata = '0;

   always #2 clk = ~clk;

   irq_aggr_top dut (
      .clk(clk), .rst_n(rst_n), .wired_irq(wired),
      .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq_out(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (mc[i]) begin mc[i] = 1'b0; mm[i] = 1'b1; end
         m_rdata = '0;
      end else begin
         if (rd) begin
            logic [31:0] v;
            v = '0;
            for (int b = 0; b < 32; b++) begin
               if (addr == 8'h00) v[b] = mc[b];
               if (addr == 8'h04) v[b] = mc[32+b];
               if (addr == 8'h20) v[b] = mm[b];
               if (addr == 8'h24) v[b] = mm[32+b];
            end
            m_rdata = v;
         end
         for (int n = 0; n < 64; n++) begin
            bit s, c;
            s = (n < 21) ? wired[n] : (wr && addr == 8'h30 && wdata == 32'(n));
            c = wr && addr == 8'((n / 32) * 4) && wdata[n % 32];
            mc[n] = s | (mc[n] & !c);
            if (wr && addr == 8'(8'h20 + (n / 32) * 4)) mm[n] = wdata[n % 32];
         end
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_irq;
         exp_irq = 1'b0;
         foreach (mc[i]) if (mc[i] && !mm[i]) exp_irq = 1'b1;
         chk("R9 model", {31'd0, irq}, {31'd0, exp_irq});
         chk("R11 model", rdata, m_rdata);
      end
   end

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0; addr = '0;
      d = rdata;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      reg_read(8'h00, v); chk("R1 cause0", v, 32'h0);
      reg_read(8'h04, v); chk("R1 cause1", v, 32'h0);
      reg_read(8'h20, v); chk("R1 mask0", v, 32'hFFFF_FFFF);
      reg_read(8'h24, v); chk("R1 mask1", v, 32'hFFFF_FFFF);

      // R5 and R2: doorbell 40 lands in word 1 bit 8
      reg_write(8'h30, 32'd40);
      reg_read(8'h04, v); chk("R5 R2 door40", v, 32'h0000_0100);
      chk("R9 masked", {31'd0, irq}, 32'd0);
      reg_write(8'h24, 32'hFFFF_FEFF);
      reg_read(8'h24, v); chk("R4 mask readback", v, 32'hFFFF_FEFF);
      chk("R9 enabled", {31'd0, irq}, 32'd1);
      reg_write(8'h04, 32'h0);
      reg_read(8'h04, v); chk("R3 zero write", v, 32'h0000_0100);
      reg_write(8'h04, 32'h0000_0100);
      reg_read(8'h04, v); chk("R3 clear", v, 32'h0);
      chk("R9 cleared", {31'd0, irq}, 32'd0);

      // R2 range edges and R6 ignored values
      reg_write(8'h30, 32'd21);
      reg_write(8'h30, 32'd63);
      reg_write(8'h30, 32'd20);
      reg_write(8'h30, 32'd64);
      reg_write(8'h30, 32'hFFFF_FFFF);
      reg_read(8'h00, v); chk("R2 R6 word0", v, 32'h0020_0000);
      reg_read(8'h04, v); chk("R2 R6 word1", v, 32'h8000_0000);
      reg_write(8'h00, 32'h0020_0000);
      reg_write(8'h04, 32'h8000_0000);
      reg_read(8'h00, v); chk("R3 clear word0", v, 32'h0);

      // R7 one-cycle wired pulse stays latched
      @(negedge clk); wired[5] = 1'b1;
      @(negedge clk); wired[5] = 1'b0;
      reg_read(8'h00, v); chk("R7 latched", v, 32'h0000_0020);
      // R8 clear while the level is high: set wins
      wired[3] = 1'b1;
      @(negedge clk);
      reg_write(8'h00, 32'h0000_0028);
      reg_read(8'h00, v); chk("R8 set wins", v, 32'h0000_0008);
      reg_write(8'h20, 32'hFFFF_FFF7);
      chk("R9 wired enabled", {31'd0, irq}, 32'd1);
      wired[3] = 1'b0;
      reg_write(8'h00, 32'h0000_0008);
      reg_read(8'h00, v); chk("R7 cleared", v, 32'h0);
      chk("R9 idle", {31'd0, irq}, 32'd0);

      // R10 bulk clear and mask
      wired[7] = 1'b1;
      reg_write(8'h30, 32'd50);
      wired[7] = 1'b0;
      reg_write(8'h00, 32'hFFFF_FFFF);
      reg_write(8'h04, 32'hFFFF_FFFF);
      reg_write(8'h20, 32'hFFFF_FFFF);
      reg_write(8'h24, 32'hFFFF_FFFF);
      reg_read(8'h00, v); chk("R10 cause0", v, 32'h0);
      reg_read(8'h04, v); chk("R10 cause1", v, 32'h0);
      reg_read(8'h20, v); chk("R10 mask0", v, 32'hFFFF_FFFF);
      reg_read(8'h24, v); chk("R10 mask1", v, 32'hFFFF_FFFF);
      chk("R10 irq", {31'd0, irq}, 32'd0);

      // R11 unmapped and doorbell addresses read zero
      reg_write(8'h30, 32'd33);
      reg_read(8'h10, v); chk("R11 unmapped", v, 32'h0);
      reg_read(8'h30, v); chk("R11 doorbell read", v, 32'h0);
      reg_read(8'h04, v); chk("R11 word1", v, 32'h0000_0002);

      repeat (2) @(negedge clk);
      summary();
   end

endmodule